// File: doc/BRIEF.md
# Triangle Down-Spread Profile Generator

This block produces a digital frequency word that follows a symmetric triangle for down-spread clocking. It is meant to feed a fractional feedback divider. It runs from one fixed reference clock. When spread is off, the frequency word equals the nominal word. When spread is on, the word starts at its lowest point, nominal minus the spread depth. It climbs linearly back to nominal over one half period, then falls at the same rate over the second half. The cycle then repeats. The word never rises above nominal.

The spread fraction is given as an unsigned Q0.16 fraction of the nominal word. It is clamped to a parameter limit, which by default is 393/65536, about 0.6 %. The half-period length, in reference cycles, and the per-cycle step are computed by software from the reference rate, the modulation rate (around 30 kHz) and the spread. The step is given in units of 2^-16 of a nominal-word LSB. The nominal word, spread fraction, step and half length are captured only at the start of a modulation period. Spread can be switched on or off at any time without a reset.

Top module: `ssc_tri_gen`

## Requirements
- R1: After reset with spread disabled, one clock edge later `freq_word` equals `nom_word` shifted left by 16 (16 fractional bits) and `offset` is 0.
- R2: On the first edge with `spread_en` high after a disabled cycle, the block enters its minimum point. After that edge, `offset` equals minus the depth, where depth = `nom_word` × min(`spread_frac`, limit) in units of 2^-16 LSB.
- R3: During the rising half, each edge reduces the below-nominal amount by `step`, floored at 0, for exactly H edges. H is `half_len`.
- R4: During the falling half, each edge raises the below-nominal amount by `step`, capped at the depth. After H-1 such edges, the next edge starts a new period at the minimum point, so one period lasts 2·H edges.
- R5: One edge after `spread_en` is sampled low, `offset` is 0 and `freq_word` equals the nominal word sampled at that edge. While spread stays disabled, the nominal word keeps following the input.
- R6: Re-enabling spread after a disable restarts the sweep from the minimum point, whatever phase the sweep was left in.
- R7: `freq_word` never exceeds nominal·2^16 and never drops below nominal·2^16 minus the depth, even when `step`·H does not equal the depth.
- R8: The nominal word, spread fraction, step and half length are captured on entry and at each period start. Changes in between have no effect until the next period start.
- R9: A `spread_frac` above the parameter limit (default 393, about 0.6 %) is treated as the limit.
- R10: A `half_len` of 0 is treated as 1, which gives a two-edge period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spread_en | input | 1 | Spread enable; may change at any time |
| nom_word | input | 16 | Nominal frequency word (integer) |
| spread_frac | input | 16 | Spread depth, Q0.16 fraction of nominal |
| half_len | input | 16 | Reference cycles per half period |
| step | input | 24 | Per-cycle change, units of 2^-16 LSB |
| freq_word | output | 32 | Instantaneous target word, 16 fractional bits |
| offset | output | 33 | Signed offset from nominal (zero or negative) |

## Verification
A wrong count or direction state shows up on `offset` within one edge. A corrupted count or direction makes the ramp turn early or late, so the value at the expected turning edge is wrong. A missing clamp gives a word below the band or above nominal on the edge where a large step overshoots. A constant captured at the wrong time shows as a slope or depth change inside a period, on the first edge after the input changes. The bench compares every cycle of each sweep against a closed-form triangle, so each of these errors is reported in the cycle it appears.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int NOM_W  = 16;
    localparam int FRAC_W = 16;
    localparam int MAG_W  = NOM_W + FRAC_W;

    typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } ramp_dir_e;
endpackage

// File: rtl/ssc_depth_calc.sv
module ssc_depth_calc #(
    parameter int NOM_W  = 16,
    parameter int FRAC_W = 16,
    parameter int LIMIT  = 393
) (
    input  logic [NOM_W-1:0]        nom,
    input  logic [FRAC_W-1:0]       frac,
    output logic [NOM_W+FRAC_W-1:0] depth
);
    localparam logic [FRAC_W-1:0] LIMIT_V = FRAC_W'(LIMIT);
    logic [FRAC_W-1:0] frac_eff;

    always_comb begin
        frac_eff = (frac > LIMIT_V) ? LIMIT_V : frac;
        depth    = (NOM_W+FRAC_W)'(nom) * (NOM_W+FRAC_W)'(frac_eff);
    end
endmodule

// File: rtl/ssc_ramp_step.sv
module ssc_ramp_step #(
    parameter int MAG_W  = 32,
    parameter int STEP_W = 24
) (
    input  logic              going_down,
    input  logic [MAG_W-1:0]  mag,
    input  logic [STEP_W-1:0] step,
    input  logic [MAG_W-1:0]  depth,
    output logic [MAG_W-1:0]  mag_next
);
    logic [MAG_W:0] step_x;
    logic [MAG_W:0] sum_x;

    always_comb begin
        step_x = (MAG_W+1)'(step);
        sum_x  = {1'b0, mag} + step_x;
        if (going_down) begin
            // frequency falls: amount below nominal grows, capped at depth
            mag_next = (sum_x > {1'b0, depth}) ? depth : sum_x[MAG_W-1:0];
        end else begin
            // frequency rises: amount below nominal shrinks, floored at zero
            mag_next = ({1'b0, mag} >= step_x) ? (mag - step_x[MAG_W-1:0]) : '0;
        end
    end
endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen #(
    parameter int NOM_W  = 16,
    parameter int FRAC_W = 16,
    parameter int HALF_W = 16,
    parameter int STEP_W = 24,
    parameter int LIMIT  = 393
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en,
    input  logic [NOM_W-1:0]        nom_word,
    input  logic [FRAC_W-1:0]       spread_frac,
    input  logic [HALF_W-1:0]       half_len,
    input  logic [STEP_W-1:0]       step,
    output logic [NOM_W+FRAC_W-1:0] freq_word,
    output logic [NOM_W+FRAC_W:0]   offset
);
    import ssc_pkg::*;
    localparam int MW = NOM_W + FRAC_W;

    typedef struct packed {
        logic              active;
        ramp_dir_e         dir;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
        logic [STEP_W-1:0] stp;
        logic [NOM_W-1:0]  nom;
        logic [MW-1:0]     depth;
        logic [MW-1:0]     mag;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [MW-1:0]     depth_new;
    logic [MW-1:0]     mag_step;
    logic [HALF_W-1:0] half_eff;
    logic              half_last;

    ssc_depth_calc #(.NOM_W(NOM_W), .FRAC_W(FRAC_W), .LIMIT(LIMIT)) u_depth (
        .nom   (nom_word),
        .frac  (spread_frac),
        .depth (depth_new)
    );

    ssc_ramp_step #(.MAG_W(MW), .STEP_W(STEP_W)) u_step (
        .going_down (st_q.dir == DIR_DOWN),
        .mag        (st_q.mag),
        .step       (st_q.stp),
        .depth      (st_q.depth),
        .mag_next   (mag_step)
    );

    always_comb begin
        half_eff  = (st_q.half == '0) ? HALF_W'(1) : st_q.half;
        half_last = (st_q.cnt == half_eff - HALF_W'(1));
        st_d      = st_q;
        if (!spread_en) begin
            st_d.active = 1'b0;
            st_d.dir    = DIR_UP;
            st_d.cnt    = '0;
            st_d.mag    = '0;
            st_d.nom    = nom_word;
        end else if (!st_q.active || (half_last && st_q.dir == DIR_DOWN)) begin
            // period start: capture constants, sit at the minimum point
            st_d.active = 1'b1;
            st_d.dir    = DIR_UP;
            st_d.cnt    = '0;
            st_d.half   = half_len;
            st_d.stp    = step;
            st_d.nom    = nom_word;
            st_d.depth  = depth_new;
            st_d.mag    = depth_new;
        end else begin
            st_d.mag = mag_step;
            if (half_last) begin
                st_d.cnt = '0;
                st_d.dir = DIR_DOWN;
            end else begin
                st_d.cnt = st_q.cnt + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freq_word = {st_q.nom, {FRAC_W{1'b0}}} - st_q.mag;
    assign offset    = -{1'b0, st_q.mag};

    // plain views of state for the bound checker
    logic              chk_active;
    logic              chk_down;
    logic [HALF_W-1:0] chk_cnt;
    logic [MW-1:0]     chk_mag;
    logic [MW-1:0]     chk_depth;
    logic [STEP_W-1:0] chk_step;
    logic [HALF_W-1:0] chk_half;
    logic [NOM_W-1:0]  chk_nom;
    assign chk_active = st_q.active;
    assign chk_down   = (st_q.dir == DIR_DOWN);
    assign chk_cnt    = st_q.cnt;
    assign chk_mag    = st_q.mag;
    assign chk_depth  = st_q.depth;
    assign chk_step   = st_q.stp;
    assign chk_half   = st_q.half;
    assign chk_nom    = st_q.nom;
endmodule

// File: rtl/ssc_tri_chk.sv
module ssc_tri_chk #(
    parameter int NOM_W  = 16,
    parameter int FRAC_W = 16,
    parameter int HALF_W = 16,
    parameter int STEP_W = 24,
    parameter int LIMIT  = 393
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    spread_en,
    input logic [NOM_W-1:0]        nom_word,
    input logic [NOM_W+FRAC_W-1:0] freq_word,
    input logic [NOM_W+FRAC_W:0]   offset,
    input logic                    active,
    input logic                    down,
    input logic [HALF_W-1:0]       cnt,
    input logic [NOM_W+FRAC_W-1:0] mag,
    input logic [NOM_W+FRAC_W-1:0] depth,
    input logic [STEP_W-1:0]       stp,
    input logic [HALF_W-1:0]       half,
    input logic [NOM_W-1:0]        nomq
);
    localparam int MW = NOM_W + FRAC_W;
    logic period_start;
    assign period_start = (cnt == '0) && !down;

    AST_DISABLE_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> (offset == '0) && (freq_word == {$past(nom_word), {FRAC_W{1'b0}}})); // R5

    AST_START_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && !active) |=> (mag == depth) && period_start); // R2

    AST_WITHIN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (mag <= depth) && ($signed(offset) <= 0)); // R7

    AST_CONST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !period_start) |->
            ($stable(stp) && $stable(half) && $stable(depth) && $stable(nomq))); // R8

    AST_SLEW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !period_start) |->
            (({1'b0, mag} <= {1'b0, $past(mag)} + (MW+1)'(stp)) &&
             ({1'b0, mag} + (MW+1)'(stp) >= {1'b0, $past(mag)}))); // R3

    AST_DEPTH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((2*MW)'(depth) <= (2*MW)'(nomq) * (2*MW)'(LIMIT))); // R9
endmodule

bind ssc_tri_gen ssc_tri_chk #(
    .NOM_W(NOM_W), .FRAC_W(FRAC_W), .HALF_W(HALF_W), .STEP_W(STEP_W), .LIMIT(LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .nom_word(nom_word),
    .freq_word(freq_word), .offset(offset), .active(chk_active), .down(chk_down),
    .cnt(chk_cnt), .mag(chk_mag), .depth(chk_depth), .stp(chk_step),
    .half(chk_half), .nomq(chk_nom)
);

// File: tb/ssc_tri_gen_bench.sv
module ssc_tri_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spread_en = 1'b0;
    logic [15:0] nom_word = 16'd1000;
    logic [15:0] spread_frac = 16'd328;
    logic [15:0] half_len = 16'd8;
    logic [23:0] step = 24'd41000;
    logic [31:0] freq_word;
    logic [32:0] offset;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    ssc_tri_gen u_ssc_tri_gen (
        .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .nom_word(nom_word),
        .spread_frac(spread_frac), .half_len(half_len), .step(step),
        .freq_word(freq_word), .offset(offset)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint depth_of(longint nom, longint frac);
        longint f = (frac > 393) ? 393 : frac;
        return nom * f;
    endfunction

    // below-nominal amount k edges after a period start
    function automatic longint tri_mag(longint k, longint d, longint s, longint h_in);
        longint h = (h_in == 0) ? 1 : h_in;
        longint p = k % (2 * h);
        longint b;
        longint v;
        if (p <= h) begin
            v = d - p * s;
            return (v < 0) ? 0 : v;
        end
        v = d - h * s;
        b = (v < 0) ? 0 : v;
        v = b + (p - h) * s;
        return (v > d) ? d : v;
    endfunction

    task automatic chk_mag(string req, longint nom, longint m);
        chk(req, "offset", $signed(offset), -m);
        chk(req, "freq_word", longint'(freq_word), (nom <<< 16) - m);
    endtask

    task automatic t_reset();
        chk("R1", "offset in reset", $signed(offset), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "freq_word after reset", longint'(freq_word), 1000 <<< 16);
        chk("R1", "offset after reset", $signed(offset), 0);
    endtask

    task automatic t_sweep(string req, longint nom, longint frac, longint h,
                           longint s, int ncyc);
        longint d = depth_of(nom, frac);
        nom_word = 16'(nom); spread_frac = 16'(frac);
        half_len = 16'(h); step = 24'(s);
        spread_en = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            tick();
            chk_mag(req, nom, tri_mag(k, d, s, h));
        end
        spread_en = 1'b0;
        tick();
        chk_mag("R5", nom, 0);
    endtask

    task automatic t_disable_reenable();
        longint d = depth_of(1000, 328);
        nom_word = 16'd1000; spread_frac = 16'd328; half_len = 16'd8; step = 24'd41000;
        spread_en = 1'b1;
        for (int k = 0; k < 11; k++) tick();
        spread_en = 1'b0;
        tick();
        chk_mag("R5", 1000, 0);
        nom_word = 16'd2000;
        tick();
        chk("R5", "nominal follows input", longint'(freq_word), 2000 <<< 16);
        nom_word = 16'd1000;
        spread_en = 1'b1;
        tick();
        chk_mag("R6", 1000, d);
        tick();
        chk_mag("R6", 1000, d - 41000);
        spread_en = 1'b0;
        tick();
    endtask

    task automatic t_const_latch();
        longint d1 = depth_of(1000, 328);
        longint d2 = depth_of(1500, 200);
        nom_word = 16'd1000; spread_frac = 16'd328; half_len = 16'd4; step = 24'd41000;
        spread_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            chk_mag("R8", 1000, tri_mag(k, d1, 41000, 4));
            if (k == 2) begin
                nom_word = 16'd1500; spread_frac = 16'd200;
                half_len = 16'd6; step = 24'd25000;
            end
        end
        for (int k = 0; k < 14; k++) begin
            tick();
            chk_mag("R8", 1500, tri_mag(k, d2, 25000, 6));
        end
        spread_en = 1'b0;
        tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #3;
        t_reset();
        t_sweep("R2 R3 R4", 1000, 328, 8, 41000, 40);
        t_sweep("R3 R4", 3000, 300, 5, 100000, 22);
        t_sweep("R7", 1000, 328, 4, 150000, 20);
        t_sweep("R7", 1000, 328, 6, 30000, 24);
        t_sweep("R9", 1000, 1000, 5, 80000, 20);
        t_sweep("R10", 1000, 328, 0, 50000, 6);
        t_disable_reenable();
        t_const_latch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule